// File: doc/BRIEF.md
# ECC Write Fault Injector

This block sits in the write-data path of one memory controller channel that carries two pseudo-channel write streams. It corrupts chosen beats of four-beat write bursts on purpose, so that the ECC checking further down the path can be exercised with known single-bit and double-bit faults. Each pseudo channel has its own lane. Each lane tracks the beat position inside the current burst and can flip low-order data bits on one chosen beat.

Software controls the block through a small register port. Each pseudo channel has two request fields, four bits each. One field asks for single-bit faults and the other for double-bit faults. Bit b of a field names beat b of the burst. A request is one-shot. It arms when its bit goes from 0 to 1, fires once on the next valid beat at that position, and then stays inert until software writes the bit to 0 and back to 1. Every beat leaves the block one clock after it enters, whether or not it was corrupted.

Top module: `wr_ecc_fault_inject`

## Requirements
- R1: After reset, all four request fields read back as 0 and no beat is corrupted.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the field that `cfg_addr` selects. Address bit 0 picks the kind (0 = single-bit, 1 = double-bit) and bit 1 picks the pseudo channel. `cfg_rdata` shows the selected field in the same cycle.
- R3: A valid beat that has its first-beat marker set is beat 0. Each later valid beat without the marker is the next position, counting modulo 4. Request bit b targets beat position b.
- R4: An armed single-bit request flips only data bit 0 of the targeted beat.
- R5: An armed double-bit request flips data bits 0 and 1 of the targeted beat and no other bit.
- R6: A request fires exactly once. Later beats at the same position pass through unchanged while the bit stays 1, and writing 1 over a bit that is already 1 does not re-arm it.
- R7: A request re-arms only when its bit goes from 0 to 1. Writing 0 to an armed bit before it fires cancels it.
- R8: Each lane registers its output with one cycle of latency. `out_valid` and `out_first` repeat the inputs of the previous cycle, and a beat that no armed request matches comes out unchanged.
- R9: When a single-bit and a double-bit request are both armed for the beat being processed, the double-bit flip is applied and both requests are consumed.
- R10: The two pseudo-channel lanes are independent. A beat on one lane neither uses nor disturbs the requests of the other lane.
- R11: Cycles with valid low are never corrupted, do not move the beat position and do not consume a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Field select: bit 0 = kind, bit 1 = pseudo channel |
| cfg_wdata | input | 4 | Value written to the selected request field |
| cfg_rdata | output | 4 | Current value of the selected request field |
| in_valid | input | 2 | Beat valid, one bit per lane |
| in_first | input | 2 | First-beat marker, one bit per lane |
| in_data | input | 128 | Beat data, 64 bits per lane, lane 0 in the low half |
| out_valid | output | 2 | Registered beat valid |
| out_first | output | 2 | Registered first-beat marker |
| out_data | output | 128 | Registered, possibly corrupted beat data |

## Verification
The bench sweeps every lane, request kind and beat position. Each pass checks three things: the request fires on the right beat, it does not fire a second time, and it fires again after a 0-then-1 rewrite. A design that arms on the level of the bit rather than on its rising edge would corrupt every burst. A design that detects the edge at the wrong moment would never re-arm.

Further cases check that:
- a request cancelled before it fires stays silent, which a design would miss if it kept the armed flag after a clear;
- a burst restarted mid-count and a run of more than four beats without a marker land on the right positions, which a beat counter that ignores the marker or skips the wrap would miss;
- idle cycles do not move the position, which a counter that advances on every clock would get wrong;
- a coincident single-bit and double-bit request produces two flipped bits and leaves nothing armed, which a design with the wrong priority or only one consumed flag would get wrong.

// File: rtl/wei_pkg.sv
package wei_pkg;
   // kind bit of the field address
   typedef enum logic {
      KIND_ONE = 1'b0,
      KIND_TWO = 1'b1
   } fault_kind_e;

   function automatic int field_index(int lane, fault_kind_e kind);
      return 2 * lane + int'(kind);
   endfunction
endpackage

// File: rtl/wei_cfg_regs.sv
module wei_cfg_regs #(
   parameter int NUM_FLD = 4,
   parameter int BEATS   = 4,
   parameter int AW      = 2
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           cfg_we,
   input  logic [AW-1:0]                  cfg_addr,
   input  logic [BEATS-1:0]               cfg_wdata,
   output logic [BEATS-1:0]               cfg_rdata,
   output logic [NUM_FLD-1:0][BEATS-1:0]  fld_rise,
   output logic [NUM_FLD-1:0][BEATS-1:0]  fld_fall
);
   logic [NUM_FLD-1:0][BEATS-1:0] fld_q;

   for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      logic sel;
      assign sel         = cfg_we && (cfg_addr == AW'(f));
      assign fld_rise[f] = sel ? (cfg_wdata & ~fld_q[f]) : '0;
      assign fld_fall[f] = sel ? (~cfg_wdata & fld_q[f]) : '0;

      always_ff @(posedge clk) begin
         if (rst)
            fld_q[f] <= '0;
         else if (sel)
            fld_q[f] <= cfg_wdata;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int f = 0; f < NUM_FLD; f++)
         if (cfg_addr == AW'(f))
            cfg_rdata = fld_q[f];
   end
endmodule

// File: rtl/wei_beat_track.sv
module wei_beat_track #(
   parameter int BEATS  = 4,
   parameter int BEAT_W = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              beat_vld,
   input  logic              beat_first,
   output logic [BEAT_W-1:0] beat_pos
);
   logic [BEAT_W-1:0] cnt_q;

   // the marker forces position zero; otherwise the running count applies
   assign beat_pos = beat_first ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (beat_vld)
         cnt_q <= beat_pos + BEAT_W'(1);
   end
endmodule

// File: rtl/wei_lane.sv
module wei_lane #(
   parameter int DATA_W   = 64,
   parameter int BEATS    = 4,
   parameter int FLIP_BIT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_first,
   input  logic [DATA_W-1:0] in_data,
   input  logic [BEATS-1:0]  rise_one,
   input  logic [BEATS-1:0]  fall_one,
   input  logic [BEATS-1:0]  rise_two,
   input  logic [BEATS-1:0]  fall_two,
   output logic              out_valid,
   output logic              out_first,
   output logic [DATA_W-1:0] out_data
);
   localparam int BEAT_W = $clog2(BEATS);

   logic [BEAT_W-1:0] pos;
   logic [BEATS-1:0]  arm_one, arm_two, hit_one, hit_two;
   logic [DATA_W-1:0] mask;

   wei_beat_track #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_trk (
      .clk        (clk),
      .rst        (rst),
      .beat_vld   (in_valid),
      .beat_first (in_first),
      .beat_pos   (pos)
   );

   for (genvar b = 0; b < BEATS; b++) begin : g_beat
      assign hit_one[b] = in_valid && (pos == BEAT_W'(b)) && arm_one[b];
      assign hit_two[b] = in_valid && (pos == BEAT_W'(b)) && arm_two[b];

      // arm on a 0->1 write, disarm on a 1->0 write or when used
      always_ff @(posedge clk) begin
         if (rst) begin
            arm_one[b] <= 1'b0;
            arm_two[b] <= 1'b0;
         end else begin
            if (rise_one[b])
               arm_one[b] <= 1'b1;
            else if (fall_one[b] || hit_one[b])
               arm_one[b] <= 1'b0;
            if (rise_two[b])
               arm_two[b] <= 1'b1;
            else if (fall_two[b] || hit_two[b])
               arm_two[b] <= 1'b0;
         end
      end
   end

   // double-bit request wins over single-bit on the same beat
   always_comb begin
      mask = '0;
      if (|hit_two)
         mask[FLIP_BIT+1 -: 2] = 2'b11;
      else if (|hit_one)
         mask[FLIP_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_first <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_first <= in_first;
         out_data  <= in_data ^ mask;
      end
   end
endmodule

// File: rtl/wr_ecc_fault_inject.sv
module wr_ecc_fault_inject
   import wei_pkg::*;
#(
   parameter int  DATA_W   = 64,
   parameter int  BEATS    = 4,
   parameter int  NUM_PC   = 2,
   parameter int  FLIP_BIT = 0,
   localparam int NUM_FLD  = 2 * NUM_PC,
   localparam int CFG_AW   = $clog2(NUM_FLD)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_we,
   input  logic [CFG_AW-1:0]        cfg_addr,
   input  logic [BEATS-1:0]         cfg_wdata,
   output logic [BEATS-1:0]         cfg_rdata,
   input  logic [NUM_PC-1:0]        in_valid,
   input  logic [NUM_PC-1:0]        in_first,
   input  logic [NUM_PC*DATA_W-1:0] in_data,
   output logic [NUM_PC-1:0]        out_valid,
   output logic [NUM_PC-1:0]        out_first,
   output logic [NUM_PC*DATA_W-1:0] out_data
);
   // elaboration-time parameter checks
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("BEATS must be a power of two of at least 2");
   end
   if (NUM_PC < 1) begin : g_bad_pc
      $error("NUM_PC must be at least 1");
   end
   if (FLIP_BIT < 0 || FLIP_BIT + 1 >= DATA_W) begin : g_bad_flip
      $error("FLIP_BIT and FLIP_BIT+1 must lie inside the data word");
   end

   logic [NUM_FLD-1:0][BEATS-1:0] fld_rise, fld_fall;

   wei_cfg_regs #(.NUM_FLD(NUM_FLD), .BEATS(BEATS), .AW(CFG_AW)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .fld_rise  (fld_rise),
      .fld_fall  (fld_fall)
   );

   for (genvar p = 0; p < NUM_PC; p++) begin : g_lane
      localparam int F1 = field_index(p, KIND_ONE);
      localparam int F2 = field_index(p, KIND_TWO);

      wei_lane #(.DATA_W(DATA_W), .BEATS(BEATS), .FLIP_BIT(FLIP_BIT)) u_lane (
         .clk       (clk),
         .rst       (rst),
         .in_valid  (in_valid[p]),
         .in_first  (in_first[p]),
         .in_data   (in_data[p*DATA_W +: DATA_W]),
         .rise_one  (fld_rise[F1]),
         .fall_one  (fld_fall[F1]),
         .rise_two  (fld_rise[F2]),
         .fall_two  (fld_fall[F2]),
         .out_valid (out_valid[p]),
         .out_first (out_first[p]),
         .out_data  (out_data[p*DATA_W +: DATA_W])
      );
   end
endmodule

// File: rtl/wei_checker.sv
module wei_checker #(
   parameter int DATA_W   = 64,
   parameter int NUM_PC   = 2,
   parameter int FLIP_BIT = 0
) (
   input logic                     clk,
   input logic                     rst,
   input logic [NUM_PC-1:0]        in_valid,
   input logic [NUM_PC-1:0]        in_first,
   input logic [NUM_PC*DATA_W-1:0] in_data,
   input logic [NUM_PC-1:0]        out_valid,
   input logic [NUM_PC-1:0]        out_first,
   input logic [NUM_PC*DATA_W-1:0] out_data
);
   localparam logic [DATA_W-1:0] WIN = DATA_W'(2'b11) << FLIP_BIT;
   localparam logic [DATA_W-1:0] LO  = DATA_W'(1'b1)  << FLIP_BIT;
   localparam logic [DATA_W-1:0] HI  = DATA_W'(2'b10) << FLIP_BIT;

   for (genvar p = 0; p < NUM_PC; p++) begin : g_chk
      // R8: valid and first-marker come out one cycle later
      a_r8_stream_delay: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> (out_valid[p] == $past(in_valid[p]) &&
                          out_first[p] == $past(in_first[p])));

      // R4 / R5: corruption stays inside the two flip positions
      a_r5_flip_window: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |->
            ((out_data[p*DATA_W +: DATA_W] ^ $past(in_data[p*DATA_W +: DATA_W])) & ~WIN) == '0);

      // R4 / R5: the upper flip bit never appears without the lower one
      a_r4_pair_shape: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |->
            ((out_data[p*DATA_W +: DATA_W] ^ $past(in_data[p*DATA_W +: DATA_W])) & WIN) != HI);

      // R11: idle cycles are never corrupted
      a_r11_idle_clean: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !out_valid[p]) |->
            out_data[p*DATA_W +: DATA_W] == $past(in_data[p*DATA_W +: DATA_W]));

      // R4: the single-bit case is exactly one flipped bit when it appears alone
      a_r4_single_low: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) &&
          $countones(out_data[p*DATA_W +: DATA_W] ^ $past(in_data[p*DATA_W +: DATA_W])) == 1) |->
            (out_data[p*DATA_W +: DATA_W] ^ $past(in_data[p*DATA_W +: DATA_W])) == LO);
   end
endmodule

bind wr_ecc_fault_inject wei_checker #(
   .DATA_W   (DATA_W),
   .NUM_PC   (NUM_PC),
   .FLIP_BIT (FLIP_BIT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_first  (in_first),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_first (out_first),
   .out_data  (out_data)
);

// File: tb/tb_wr_ecc_fault_inject.sv
`timescale 1ns/1ps
module tb_wr_ecc_fault_inject;
   localparam int DW = 64;
   localparam int NP = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic          cfg_we;
   logic [1:0]    cfg_addr;
   logic [3:0]    cfg_wdata;
   logic [3:0]    cfg_rdata;
   logic [NP-1:0] in_valid, in_first, out_valid, out_first;
   logic [NP*DW-1:0] in_data, out_data;

   always #4 clk = ~clk;   // 125 MHz

   wr_ecc_fault_inject dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .in_valid(in_valid), .in_first(in_first), .in_data(in_data),
      .out_valid(out_valid), .out_first(out_first), .out_data(out_data)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // bench model: [lane][kind][beat]
   bit reg_m [2][2][4];
   bit arm_m [2][2][4];
   int cnt_m [2];

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int lane, int kind, logic [3:0] val, string tag);
      cfg_we    = 1'b1;
      cfg_addr  = 2'(2 * lane + kind);
      cfg_wdata = val;
      for (int b = 0; b < 4; b++) begin
         if (val[b] && !reg_m[lane][kind][b]) arm_m[lane][kind][b] = 1;
         if (!val[b] && reg_m[lane][kind][b]) arm_m[lane][kind][b] = 0;
         reg_m[lane][kind][b] = val[b];
      end
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      check(cfg_rdata == val, tag, 64'(cfg_rdata), 64'(val));
   endtask

   function automatic logic [63:0] mk(int a, int b, int c);
      return (64'(a * 131 + b * 17 + c + 5)) * 64'h9E37_79B9_7F4A_7C15;
   endfunction

   task automatic beat(int lane, bit first, logic [63:0] d, string tag);
      int pos;
      logic [63:0] mask, exp;
      pos  = first ? 0 : cnt_m[lane];
      mask = 64'h0;
      if (arm_m[lane][1][pos]) mask = 64'h3;
      else if (arm_m[lane][0][pos]) mask = 64'h1;
      arm_m[lane][0][pos] = 0;
      arm_m[lane][1][pos] = 0;
      cnt_m[lane] = (pos + 1) % 4;
      exp = d ^ mask;
      in_valid[lane] = 1'b1;
      in_first[lane] = first;
      in_data[lane*DW +: DW] = d;
      @(posedge clk);
      @(negedge clk);
      in_valid[lane] = 1'b0;
      in_first[lane] = 1'b0;
      check(out_valid[lane] && out_first[lane] == first, "R8", 64'(out_valid[lane]), 64'h1);
      check(out_data[lane*DW +: DW] == exp, tag, out_data[lane*DW +: DW], exp);
   endtask

   task automatic idle(int lane, logic [63:0] d);
      in_valid[lane] = 1'b0;
      in_data[lane*DW +: DW] = d;
      @(posedge clk);
      @(negedge clk);
      check(!out_valid[lane] && out_data[lane*DW +: DW] == d, "R11",
            out_data[lane*DW +: DW], d);
   endtask

   task automatic burst(int lane, int seed, string tag);
      for (int i = 0; i < 4; i++) beat(lane, i == 0, mk(lane, seed, i), tag);
   endtask

   initial begin
      rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
      in_valid = 0; in_first = 0; in_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         cfg_addr = 2'(a);
         #1;
         check(cfg_rdata == 4'h0, "R1", 64'(cfg_rdata), 64'h0);
      end
      @(negedge clk);
      check(out_valid == 2'b00, "R1", 64'(out_valid), 64'h0);
      burst(0, 900, "R1");
      burst(1, 901, "R1");

      // sweep every lane, kind and beat
      for (int p = 0; p < 2; p++)
         for (int k = 0; k < 2; k++)
            for (int b = 0; b < 4; b++) begin
               wr(p, k, 4'(1 << b), "R2");
               burst(p, 10 * b + k, (k == 0) ? "R4" : "R5");
               burst(p, 10 * b + k + 100, "R6");
               wr(p, k, 4'(1 << b), "R2");
               burst(p, 10 * b + k + 200, "R6");
               wr(p, k, 4'h0, "R2");
               wr(p, k, 4'(1 << b), "R2");
               burst(p, 10 * b + k + 300, "R7");
               wr(p, k, 4'h0, "R2");
            end

      // R7: cancel before firing
      wr(0, 0, 4'h4, "R2");
      wr(0, 0, 4'h0, "R2");
      burst(0, 400, "R7");

      // R9: coincident requests on beat 2
      wr(1, 0, 4'h4, "R2");
      wr(1, 1, 4'h4, "R2");
      burst(1, 410, "R9");
      burst(1, 411, "R9");
      wr(1, 0, 4'h0, "R2");
      wr(1, 1, 4'h0, "R2");

      // R3: restart mid-burst and a long run that wraps
      wr(0, 1, 4'h1, "R2");
      beat(0, 1, mk(0, 420, 0), "R3");
      beat(0, 0, mk(0, 420, 1), "R3");
      wr(0, 0, 4'h2, "R2");
      beat(0, 1, mk(0, 421, 0), "R3");
      for (int i = 1; i < 7; i++) beat(0, 0, mk(0, 421, i), "R3");
      wr(0, 0, 4'h0, "R2");
      wr(0, 1, 4'h0, "R2");

      // R10: traffic on lane 1 leaves lane 0 request pending
      wr(0, 0, 4'h8, "R2");
      burst(1, 430, "R10");
      burst(0, 431, "R10");
      wr(0, 0, 4'h0, "R2");

      // R11: idle gaps do not advance position or consume
      wr(1, 1, 4'h2, "R2");
      beat(1, 1, mk(1, 440, 0), "R11");
      idle(1, mk(1, 440, 9));
      idle(1, mk(1, 440, 8));
      beat(1, 0, mk(1, 440, 1), "R11");
      beat(1, 0, mk(1, 440, 2), "R11");
      wr(1, 1, 4'h0, "R2");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule